// File: doc/BRIEF.md
# Integrating Loss-of-Frame Detector

This block turns a per-frame severely-errored-frame indication from an upstream framer into a stable loss-of-frame defect flag. The framer presents one strobe per received frame on `frame_tick_i`, with `sef_i` valid on that strobe. The block keeps an integrating count of errored frames and a run count of consecutive in-frame frames. It declares the defect once errored frames add up to a 3 ms window. It withdraws the defect once a 3 ms run of clean frames has been seen.

Every supported line rate uses a 125 µs frame, so the 3 ms window is 24 frame strobes. The rates covered are the 155 Mb/s, 622 Mb/s and 2.5 Gb/s SDH/SONET rates. The counters advance only on strobes, so the window stays the same length in absolute time at any of these rates and for any number of byte clocks per frame. A short burst of errors that repeats after a long enough clean gap never adds up to the declaration threshold.

Top module: `lof_integrator`

## Requirements
- R1: When `rst_ni` goes low, the reset takes effect at once and asynchronously. It drives `lof_o` low and empties both counters, so 24 errored strobes are needed after the reset is released before `lof_o` rises.
- R2: While `lof_o` is low, it rises on the clock edge that samples the 24th errored strobe (`frame_tick_i`=1, `sef_i`=1) counted since the last time the error count was emptied. After 23 such strobes it is still low.
- R3: While `lof_o` is low, a run of 24 consecutive in-frame strobes (`frame_tick_i`=1, `sef_i`=0) empties the error count. A pattern of 8 errored strobes followed by 24 in-frame strobes, repeated, never raises `lof_o`.
- R4: The error count accumulates over strobes that are not consecutive. With 8 errored strobes and then 16 in-frame strobes, repeated, `lof_o` rises on the 24th errored strobe.
- R5: While `lof_o` is high, it falls on the edge that samples the 24th consecutive in-frame strobe. Any errored strobe restarts that run from zero.
- R6: On cycles with `frame_tick_i` low, no state changes whatever `sef_i` does.
- R7: Both counts saturate at 24. After any number of errored strobes in a row, exactly 24 in-frame strobes clear `lof_o`.
- R8: When `lof_o` falls, the error count is empty, so a fresh 24 errored strobes are needed to raise it again.
- R9: The outcome depends only on the sequence of strobes, not on how many clock cycles separate them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_tick_i | input | 1 | One-cycle strobe per received frame |
| sef_i | input | 1 | Severely-errored-frame condition, sampled with the strobe |
| lof_o | output | 1 | Registered loss-of-frame defect flag |

## Verification
The only port that shows internal state is `lof_o`, so a wrong count is visible only at the two threshold crossings. A lost or extra increment in the error count moves the rising edge of `lof_o` by one strobe. A count that is not emptied makes the periodic-burst pattern raise `lof_o` within a few bursts. A run count that is not restarted makes `lof_o` fall earlier than 24 strobes after the last errored strobe. The bench compares `lof_o` with a behavioural model on every cycle. Because of this, each of these faults is reported on the first strobe at which the flag's edge should, or should not, have occurred.

// File: rtl/lof_pkg.sv
package lof_pkg;
  localparam int unsigned DEF_WINDOW = 24;  // 3 ms of 125 us frames

  typedef enum logic {
    ST_IN_FRAME = 1'b0,
    ST_LOF      = 1'b1
  } lof_state_e;
endpackage

// File: rtl/lof_sat_cnt.sv
module lof_sat_cnt #(
  parameter int unsigned MAX = 24,
  parameter int unsigned W   = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         near_o
);
  localparam logic [W-1:0] MAX_V  = W'(MAX);
  localparam logic [W-1:0] NEAR_V = W'(MAX - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (inc_i && cnt_o != MAX_V)   cnt_o <= cnt_o + 1'b1;
  end

  // next increment reaches (or stays at) the limit
  assign near_o = (cnt_o >= NEAR_V);

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= MAX_V);
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i || inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/lof_state.sv
module lof_state
  import lof_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic lof_o
);
  lof_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IN_FRAME: if (set_i) st_d = ST_LOF;
      ST_LOF:      if (clr_i) st_d = ST_IN_FRAME;
      default:     st_d = ST_IN_FRAME;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IN_FRAME;
    else         st_q <= st_d;
  end

  assign lof_o = (st_q == ST_LOF);

  a_r2_rise_needs_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lof_o) |-> $past(set_i));
  a_r5_fall_needs_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lof_o) |-> $past(clr_i));
endmodule

// File: rtl/lof_integrator.sv
module lof_integrator #(
  parameter int unsigned WINDOW = lof_pkg::DEF_WINDOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_tick_i,
  input  logic sef_i,
  output logic lof_o
);
  localparam int unsigned CW = $clog2(WINDOW + 1);

  logic          bad_tick, good_tick;
  logic          bad_near, good_near;
  logic          bad_hit, good_hit;
  logic [CW-1:0] bad_cnt, good_cnt;

  assign bad_tick  = frame_tick_i &  sef_i;
  assign good_tick = frame_tick_i & ~sef_i;
  assign bad_hit   = bad_tick  & bad_near;
  assign good_hit  = good_tick & good_near;

  // integrating errored-frame accumulator, emptied by a full clean run
  lof_sat_cnt #(.MAX(WINDOW), .W(CW)) u_bad_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (good_hit),
    .inc_i  (bad_tick),
    .cnt_o  (bad_cnt),
    .near_o (bad_near)
  );

  // consecutive in-frame run, restarted by any errored frame
  lof_sat_cnt #(.MAX(WINDOW), .W(CW)) u_good_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bad_tick),
    .inc_i  (good_tick),
    .cnt_o  (good_cnt),
    .near_o (good_near)
  );

  lof_state u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (bad_hit),
    .clr_i  (good_hit),
    .lof_o  (lof_o)
  );

  a_r6_stable_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> $stable(lof_o));
  a_r3_acc_emptied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_tick && good_cnt == CW'(WINDOW - 1)) |=> (bad_cnt == '0));
  a_r5_fall_on_clean_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lof_o) |-> $past(frame_tick_i && !sef_i));
  a_r8_empty_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lof_o) |-> (bad_cnt == '0));
endmodule

// File: tb/lof_integrator_tb.sv
module lof_integrator_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic sef = 1'b0;
  logic lof;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";

  // behavioural reference
  int  m_bad = 0, m_good = 0;
  bit  m_lof = 1'b0;

  always #5 clk = ~clk;

  lof_integrator u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .frame_tick_i (tick),
    .sef_i        (sef),
    .lof_o        (lof)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_bad = 0; m_good = 0; m_lof = 1'b0;
    end else if (tick) begin
      if (sef) begin
        m_good = 0;
        if (m_bad < 24) m_bad++;
        if (!m_lof && m_bad == 24) m_lof = 1'b1;
      end else begin
        if (m_good < 24) m_good++;
        if (m_good == 24) begin m_bad = 0; m_lof = 1'b0; end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    checks++;
    if (lof !== m_lof) begin
      fails++;
      $display("FAIL %s cycle %0d: lof_o=%b expected %b", cur_req, cyc, lof, m_lof);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check_lof(input bit exp, input string req);
    checks++;
    if (lof !== exp) begin
      fails++;
      $display("FAIL %s: lof_o=%b expected %b", req, lof, exp);
    end
  endtask

  // one frame strobe, then gap idle cycles with sef toggled (R6)
  task automatic frames(input int n, input bit bad, input int gap, input string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; sef = bad;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); tick = 1'b0; sef = (g % 2 == 0) ? ~bad : bad;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_lof(1'b0, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_lof(1'b0, "R1");

    // R2 declare threshold
    frames(23, 1'b1, 2, "R2");
    check_lof(1'b0, "R2");
    frames(1, 1'b1, 2, "R2");
    check_lof(1'b1, "R2");

    // R5 clean run restarted by an errored strobe
    frames(23, 1'b0, 2, "R5");
    check_lof(1'b1, "R5");
    frames(1, 1'b1, 2, "R5");
    frames(23, 1'b0, 2, "R5");
    check_lof(1'b1, "R5");
    frames(1, 1'b0, 2, "R5");
    check_lof(1'b0, "R5");

    // R8 fresh accumulation after clear
    frames(23, 1'b1, 1, "R8");
    check_lof(1'b0, "R8");
    frames(1, 1'b1, 1, "R8");
    check_lof(1'b1, "R8");
    frames(24, 1'b0, 1, "R8");
    check_lof(1'b0, "R8");

    // R3 periodic bursts with long clean gaps
    for (int k = 0; k < 5; k++) begin
      frames(8, 1'b1, 1, "R3");
      frames(24, 1'b0, 1, "R3");
      check_lof(1'b0, "R3");
    end

    // R4 integration over short clean gaps
    for (int k = 0; k < 3; k++) begin
      frames(8, 1'b1, 1, "R4");
      check_lof(k == 2, "R4");
      frames(16, 1'b0, 1, "R4");
    end
    frames(24, 1'b0, 1, "R4");
    check_lof(1'b0, "R4");

    // R7 saturation
    frames(100, 1'b1, 1, "R7");
    check_lof(1'b1, "R7");
    frames(23, 1'b0, 1, "R7");
    check_lof(1'b1, "R7");
    frames(1, 1'b0, 1, "R7");
    check_lof(1'b0, "R7");

    // R9 strobe spacing does not matter
    frames(10, 1'b1, 1, "R9");
    frames(10, 1'b1, 7, "R9");
    frames(3, 1'b1, 30, "R9");
    check_lof(1'b0, "R9");
    frames(1, 1'b1, 13, "R9");
    check_lof(1'b1, "R9");
    frames(24, 1'b0, 5, "R9");
    check_lof(1'b0, "R9");

    // R6 long idle with sef high does not advance
    frames(23, 1'b1, 1, "R6");
    cur_req = "R6";
    @(negedge clk); tick = 1'b0; sef = 1'b1;
    repeat (50) @(negedge clk);
    check_lof(1'b0, "R6");
    frames(1, 1'b1, 1, "R6");
    check_lof(1'b1, "R6");

    // R1 asynchronous reset while declared
    cur_req = "R1";
    @(negedge clk); #2 rst_ni = 1'b0;
    #1 check_lof(1'b0, "R1");
    @(negedge clk); rst_ni = 1'b1;
    frames(23, 1'b1, 1, "R1");
    check_lof(1'b0, "R1");
    frames(1, 1'b1, 1, "R1");
    check_lof(1'b1, "R1");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule